// File: doc/BRIEF.md
# Staged-Register Memory Controller

This block is a byte-wide random access memory that a client can reach only through two staging registers. One register holds the address and the other holds the data word. The client first writes the address register. For a write it also writes the data register. It then raises a one-cycle fetch or store command. A small controller carries out the access against the cell array. It raises a done flag one cycle after the command. After a fetch, the addressed cell's value is waiting in the data register.

The address width is a parameter, and the array always holds two to the power of that width cells. A decoder on the address register picks exactly one cell for each access. Every access takes the same number of cycles, whatever the address. Reset is synchronous and active high. It clears both registers, the done flag and every cell.

Top module: `mmc_top`

## Requirements
- R1: While `rst` is high at a clock edge, `mar_out`, `mdr_out` and `done` become zero and every cell becomes 0x00. After reset, a fetch of any address returns 0x00.
- R2: On an edge where `mar_load` is high, `mar_out` takes `mar_in`. With `mar_load` low, `mar_out` keeps its value whatever `mar_in` does.
- R3: On an edge where `mdr_load` is high and no fetch is performed, `mdr_out` takes `mdr_in`. With neither `mdr_load` nor a fetch, `mdr_out` keeps its value.
- R4: On an edge where `fetch_cmd` is high and `store_cmd` is low, the data register is loaded with the cell addressed by the address register. The value shows on `mdr_out` in the following cycle, the same cycle in which `done` is high.
- R5: On an edge where `store_cmd` is high, the cell addressed by the address register is written with the data register's value. `mdr_out` is not changed by the store, and a later fetch of that address returns the stored value.
- R6: `done` is high in exactly the cycle after each cycle in which `fetch_cmd` or `store_cmd` is high, and low in every other cycle.
- R7: When `fetch_cmd` and `store_cmd` are high together, only the store is performed. The data register is not overwritten from memory.
- R8: A command uses the register values held before its edge. A `mar_load` in the same cycle only affects later commands. A fetch in the same cycle as `mdr_load` leaves the fetched value in the data register. A store in the same cycle as `mdr_load` writes the old data register value.
- R9: `done` follows every command after the same one-cycle delay at every address.
- R10: A store changes only the addressed cell; every other cell keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mar_load | input | 1 | Load enable of the address register |
| mar_in | input | ADDR_W | New address register value |
| mdr_load | input | 1 | Load enable of the data register |
| mdr_in | input | 8 | New data register value |
| fetch_cmd | input | 1 | One-cycle read command |
| store_cmd | input | 1 | One-cycle write command (wins over read) |
| mar_out | output | ADDR_W | Address register contents |
| mdr_out | output | 8 | Data register contents |
| done | output | 1 | Access complete, one cycle after the command |

## Verification
The embedded properties check several rules on every cycle:
- the register hold and load rules;
- the one-cycle done timing after any command;
- the fetched word landing in the data register;
- the data register staying untouched by a store or a simultaneous command;
- the decoder selecting exactly one cell.

What no single-cycle property can show is carried by the bench's scenarios:
- reset clearing every cell;
- each address holding its own stored value across the full array;
- a single store leaving all other cells intact;
- the precedence of same-cycle register loads against commands.

The bench establishes these by sweeping every address against a bench-side model of the array.

// File: rtl/mmc_pkg.sv
package mmc_pkg;

    localparam int CELL_W = 8;

    typedef logic [CELL_W-1:0] cell_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic  mar_ld;
        logic  mdr_ld;
        op_e   op;
    } ctl_t;

    // Store outranks fetch when both are requested.
    function automatic op_e pick_op(input logic rd_req, input logic wr_req);
        if (wr_req)
            return OP_WRITE;
        else if (rd_req)
            return OP_READ;
        else
            return OP_IDLE;
    endfunction

endpackage

// File: rtl/mmc_addr_decode.sv
module mmc_addr_decode #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic [(1<<ADDR_W)-1:0] sel
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < DEPTH; g++) begin : g_line
        assign sel[g] = (addr == ADDR_W'(g));
    end

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(sel) == 1);

endmodule

// File: rtl/mmc_cell_array.sv
module mmc_cell_array
    import mmc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [(1<<ADDR_W)-1:0] sel,
    input  logic                   wr,
    input  cell_t                  wdata,
    output cell_t                  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    cell_t cells [DEPTH];
    logic [DEPTH-1:0] wr_line;

    assign wr_line = sel & {DEPTH{wr}};

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= '0;
            else if (wr_line[g])
                cells[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            rdata = rdata | (sel[i] ? cells[i] : '0);
        end
    end

    // R10
    one_write_line_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_line));

    // R5
    write_commit_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> rdata == $past(wdata) || !$stable(sel));

endmodule

// File: rtl/mmc_fsc.sv
module mmc_fsc
    import mmc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fetch_req,
    input  logic store_req,
    output op_e  op,
    output logic done
);
    assign op = pick_op(fetch_req, store_req);

    always_ff @(posedge clk) begin
        if (rst)
            done <= 1'b0;
        else
            done <= (op != OP_IDLE);
    end

    // R6
    done_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req || store_req) |=> done);

    // R6
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
        !(fetch_req || store_req) |=> !done);

    // R7
    store_wins_chk: assert property (@(posedge clk) disable iff (rst)
        store_req |-> op == OP_WRITE);

endmodule

// File: rtl/mmc_top.sv
module mmc_top
    import mmc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mar_load,
    input  logic [ADDR_W-1:0] mar_in,
    input  logic              mdr_load,
    input  logic [7:0]        mdr_in,
    input  logic              fetch_cmd,
    input  logic              store_cmd,
    output logic [ADDR_W-1:0] mar_out,
    output logic [7:0]        mdr_out,
    output logic              done
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] mar_q;
    cell_t             mdr_q;
    logic [DEPTH-1:0]  sel;
    cell_t             rd_word;
    ctl_t              ctl;
    op_e               op;

    assign ctl.mar_ld = mar_load;
    assign ctl.mdr_ld = mdr_load;
    assign ctl.op     = op;

    mmc_fsc u_fsc (
        .clk       (clk),
        .rst       (rst),
        .fetch_req (fetch_cmd),
        .store_req (store_cmd),
        .op        (op),
        .done      (done)
    );

    mmc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk  (clk),
        .rst  (rst),
        .addr (mar_q),
        .sel  (sel)
    );

    mmc_cell_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .wr    (ctl.op == OP_WRITE),
        .wdata (mdr_q),
        .rdata (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mar_q <= '0;
        else if (ctl.mar_ld)
            mar_q <= mar_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mdr_q <= '0;
        else if (ctl.op == OP_READ)
            mdr_q <= rd_word;
        else if (ctl.mdr_ld)
            mdr_q <= mdr_in;
    end

    assign mar_out = mar_q;
    assign mdr_out = mdr_q;

    // R2
    mar_load_chk: assert property (@(posedge clk) disable iff (rst)
        mar_load |=> mar_out == $past(mar_in));

    // R2
    mar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mar_load |=> $stable(mar_out));

    // R3
    mdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mdr_load && !fetch_cmd) |=> $stable(mdr_out));

    // R4
    fetch_data_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_cmd && !store_cmd) |=> mdr_out == $past(rd_word));

    // R7
    store_keeps_mdr_chk: assert property (@(posedge clk) disable iff (rst)
        (store_cmd && !mdr_load) |=> $stable(mdr_out));

endmodule

// File: tb/mmc_top_tb_top.sv
module mmc_top_tb_top;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mar_load = 1'b0;
    logic [AW-1:0] mar_in = '0;
    logic          mdr_load = 1'b0;
    logic [7:0]    mdr_in = '0;
    logic          fetch_cmd = 1'b0;
    logic          store_cmd = 1'b0;
    logic [AW-1:0] mar_out;
    logic [7:0]    mdr_out;
    logic          done;

    logic [7:0] model [DEPTH];
    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    mmc_top #(.ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .mar_load  (mar_load),
        .mar_in    (mar_in),
        .mdr_load  (mdr_load),
        .mdr_in    (mdr_in),
        .fetch_cmd (fetch_cmd),
        .store_cmd (store_cmd),
        .mar_out   (mar_out),
        .mdr_out   (mdr_out),
        .done      (done)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            fails = fails + 1;
            report();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 8'hFF);
    endfunction

    task automatic set_mar(input int a);
        mar_load = 1'b1; mar_in = AW'(a);
        @(negedge clk);
        mar_load = 1'b0;
    endtask

    task automatic set_mdr(input logic [7:0] d);
        mdr_load = 1'b1; mdr_in = d;
        @(negedge clk);
        mdr_load = 1'b0;
    endtask

    // Issue a command pulse; check done (R6, R9) and clear all drives.
    task automatic command(input logic f, input logic s, input string req);
        fetch_cmd = f; store_cmd = s;
        @(negedge clk);
        fetch_cmd = 1'b0; store_cmd = 1'b0; mar_load = 1'b0; mdr_load = 1'b0;
        check({req, "/R6 done high"}, done, 1);
    endtask

    task automatic fetch_at(input int a, input string req);
        set_mar(a);
        command(1'b1, 1'b0, req);
        check({req, "/R4 fetched data"}, mdr_out, model[a]);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 register reset values
        check("R1 mar", mar_out, 0);
        check("R1 mdr", mdr_out, 0);
        check("R1 done", done, 0);

        // R1 R9 every cell reads zero, same latency everywhere
        for (int a = 0; a < DEPTH; a++) fetch_at(a, "R1/R9");
        @(negedge clk);
        check("R6 done low when idle", done, 0);

        // R5 store every address
        for (int a = 0; a < DEPTH; a++) begin
            set_mar(a);
            set_mdr(pat(a));
            command(1'b0, 1'b1, "R5");
            model[a] = pat(a);
            check("R5 mdr unchanged by store", mdr_out, pat(a));
        end
        for (int a = 0; a < DEPTH; a++) fetch_at(a, "R5");

        // R10 single store leaves all other cells intact
        set_mar(8'h55);
        set_mdr(8'hA5);
        command(1'b0, 1'b1, "R10");
        model[8'h55] = 8'hA5;
        for (int a = 0; a < DEPTH; a++) fetch_at(a, "R10");

        // R7 simultaneous commands: store only
        set_mar(3);
        set_mdr(8'h3C);
        command(1'b1, 1'b1, "R7");
        model[3] = 8'h3C;
        check("R7 mdr not overwritten", mdr_out, 8'h3C);
        set_mdr(8'h00);
        fetch_at(3, "R7");

        // R8 fetch with same-cycle mar_load uses old address
        set_mar(10);
        mar_load = 1'b1; mar_in = AW'(20);
        command(1'b1, 1'b0, "R8");
        check("R8 fetch used old MAR", mdr_out, model[10]);
        check("R8 MAR took new value", mar_out, 20);

        // R8 fetch beats same-cycle mdr_load
        mdr_load = 1'b1; mdr_in = 8'hEE;
        command(1'b1, 1'b0, "R8");
        check("R8 fetch over mdr_load", mdr_out, model[20]);

        // R8 store with same-cycle mdr_load writes old MDR
        set_mdr(8'h77);
        mdr_load = 1'b1; mdr_in = 8'h11;
        command(1'b0, 1'b1, "R8");
        model[20] = 8'h77;
        check("R8 mdr_load during store", mdr_out, 8'h11);
        fetch_at(20, "R8");

        // R2 R3 hold without load enables
        set_mar(7);
        set_mdr(8'h5A);
        for (int k = 0; k < 5; k++) begin
            mar_in = AW'(k * 11 + 1); mdr_in = 8'(k * 29 + 3);
            @(negedge clk);
            check("R2 MAR holds", mar_out, 7);
            check("R3 MDR holds", mdr_out, 8'h5A);
        end
        set_mar(9);
        check("R2 MAR loads", mar_out, 9);
        set_mdr(8'hC3);
        check("R3 MDR loads", mdr_out, 8'hC3);

        // R1 reset clears stored cells again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mdr after reset", mdr_out, 0);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        fetch_at(8'h55, "R1");
        fetch_at(3, "R1");

        report();
    end

endmodule